// File: doc/BRIEF.md
# ADC conversion trigger controller

This block sits between a simple byte-wide register bus and an external successive-approximation converter core. It sequences conversions for that core. It holds two registers. The channel register latches a 5-bit input code. The status register holds the trigger-mode bit, the two compare configuration bits that are passed on to compare logic elsewhere, and a read-only flag that shows whether a conversion is in progress.

A conversion can start in one of two ways, and the mode bit picks which. In software mode, a bus write to the channel register starts it. In hardware mode, a rising edge on the trigger pin starts it. Either way, the block sends a one-cycle start pulse to the converter together with the latched channel code. It then holds the active flag until the converter returns its one-cycle done strobe. The all-ones channel code switches the converter off. Writing that code during a conversion aborts the conversion at once, with no done strobe expected.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, the channel register (address 0) reads 0x1F, the status register (address 1) reads 0x00, and conv_start is 0.
- R2: When status bit 6 is 0 (software mode), a write to address 0 with a code other than 11111 drives conv_start high for exactly the one cycle after the write edge. In that cycle conv_chan equals the written code, and status bit 7 reads 1. This holds for every such code, including 11100, 11101 and 11110, and also when a conversion is already active (the conversion restarts).
- R3: conv_done while active clears status bit 7 in the following cycle. conv_done while idle leaves bit 7 at 0.
- R4: When status bit 6 is 1 (hardware mode), a 0-to-1 change on hw_trig while idle, with a channel other than 11111, gives one conv_start pulse in the cycle after the edge is sampled. Holding hw_trig high does not repeat the pulse, and with channel 11111 no pulse is given.
- R5: A hw_trig rising edge while a conversion is active is ignored: there is no conv_start and bit 7 stays 1.
- R6: In hardware mode, a write to address 0 updates the channel (readback and conv_chan) but gives no conv_start. In software mode, hw_trig edges give no conv_start.
- R7: Writing code 11111 to address 0 while active clears bit 7 in the next cycle without a conv_start. Writing it while idle gives no conv_start.
- R8: Status bits 6, 5 and 4 are writable. Bit 7 ignores writes. Status bits 3:0 and channel bits 7:5 always read 0.
- R9: Output cmp_en follows status bit 5 and output cmp_gt follows status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 channel, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| hw_trig | input | 1 | Hardware trigger input |
| conv_done | input | 1 | One-cycle conversion-complete strobe from the converter |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 5 | Latched channel code |
| cmp_en | output | 1 | Compare enable configuration |
| cmp_gt | output | 1 | Compare greater-than configuration |

## Verification
The bench sweeps all 32 channel codes in software mode. A design that decoded the off code wrongly would pulse on 11111 or miss one of the reference codes, and a start stretched over two cycles shows up in the cycle after the pulse. In hardware mode the bench holds the trigger high and re-fires it during a conversion: a level-sensitive design would keep restarting, and one without the busy check would emit a second pulse. It also aborts with the off code and sends stray done strobes while idle, which catch a design that waits for done after an abort or lets done set the flag. Finally, it sweeps the three writable status bits with the reserved bits set, which exposes any leakage into bits 3:0 or into the active flag.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int DATA_W = 8;
  localparam int CHAN_W = 5;
  localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

  localparam int ST_ACT = 7;
  localparam int ST_HW  = 6;
  localparam int ST_CEN = 5;
  localparam int ST_CGT = 4;

  function automatic logic chan_is_off(input logic [CHAN_W-1:0] code);
    return code == CHAN_OFF;
  endfunction

  function automatic logic [DATA_W-1:0] status_pack(input logic act, input logic hw,
                                                    input logic cen, input logic cgt);
    logic [DATA_W-1:0] v;
    v = '0;
    v[ST_ACT] = act;
    v[ST_HW]  = hw;
    v[ST_CEN] = cen;
    v[ST_CGT] = cgt;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] chan_pack(input logic [CHAN_W-1:0] code);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CHAN_W-1:0] = code;
    return v;
  endfunction
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= trig_in;
  end

  assign rise_o = trig_in & ~prev_q;
endmodule

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
  import adc_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              active,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              chan_wr,
  output logic [CHAN_W-1:0] chan_new,
  output logic [CHAN_W-1:0] chan_q,
  output logic              trig_hw,
  output logic              cmp_en,
  output logic              cmp_gt
);
  logic stat_wr;

  assign chan_wr  = bus_wr & ~bus_addr;
  assign stat_wr  = bus_wr &  bus_addr;
  assign chan_new = bus_wdata[CHAN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= CHAN_OFF;
      trig_hw <= 1'b0;
      cmp_en  <= 1'b0;
      cmp_gt  <= 1'b0;
    end else begin
      if (chan_wr) chan_q <= chan_new;
      if (stat_wr) begin
        trig_hw <= bus_wdata[ST_HW];
        cmp_en  <= bus_wdata[ST_CEN];
        cmp_gt  <= bus_wdata[ST_CGT];
      end
    end
  end

  always_comb begin
    if (bus_addr) bus_rdata = status_pack(active, trig_hw, cmp_en, cmp_gt);
    else          bus_rdata = chan_pack(chan_q);
  end
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_wr,
  input  logic [CHAN_W-1:0] chan_new,
  input  logic [CHAN_W-1:0] chan_cur,
  input  logic              trig_hw,
  input  logic              hw_rise,
  input  logic              conv_done,
  output logic              active,
  output logic              start_evt,
  output logic              abort_evt,
  output logic              conv_start
);
  logic [CHAN_W-1:0] eff_code;
  logic              sw_start;
  logic              hw_start;

  assign eff_code  = chan_wr ? chan_new : chan_cur;
  assign sw_start  = chan_wr & ~trig_hw & ~chan_is_off(chan_new);
  assign hw_start  = trig_hw & hw_rise & ~active & ~chan_is_off(eff_code);
  assign start_evt = sw_start | hw_start;
  assign abort_evt = chan_wr & chan_is_off(chan_new) & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= start_evt;
      if (start_evt)                   active <= 1'b1;
      else if (abort_evt || conv_done) active <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_trig,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              cmp_en,
  output logic              cmp_gt
);
  logic              active_w;
  logic              trig_hw_w;
  logic              hw_rise_w;
  logic              chan_wr_w;
  logic [CHAN_W-1:0] chan_new_w;
  logic [CHAN_W-1:0] chan_q_w;
  logic              start_evt_w;
  logic              abort_evt_w;

  adc_trig_edge u_edge (
    .clk(clk), .rst_n(rst_n), .trig_in(hw_trig), .rise_o(hw_rise_w)
  );

  adc_trig_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .active(active_w), .bus_rdata(bus_rdata),
    .chan_wr(chan_wr_w), .chan_new(chan_new_w), .chan_q(chan_q_w),
    .trig_hw(trig_hw_w), .cmp_en(cmp_en), .cmp_gt(cmp_gt)
  );

  adc_trig_seq u_seq (
    .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr_w), .chan_new(chan_new_w),
    .chan_cur(chan_q_w), .trig_hw(trig_hw_w), .hw_rise(hw_rise_w),
    .conv_done(conv_done), .active(active_w), .start_evt(start_evt_w),
    .abort_evt(abort_evt_w), .conv_start(conv_start)
  );

  assign conv_chan = chan_q_w;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk
  import adc_trig_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              conv_start,
  input logic              conv_done,
  input logic [CHAN_W-1:0] conv_chan,
  input logic              active_w,
  input logic              trig_hw_w,
  input logic              hw_rise_w,
  input logic              chan_wr_w,
  input logic              abort_evt_w,
  input logic              start_evt_w
);
  a_r2_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> active_w);

  a_r2_start_not_off: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !chan_is_off(conv_chan));

  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && conv_done && !start_evt_w) |=> !active_w);

  a_r5_busy_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hw_w && active_w && hw_rise_w && !chan_wr_w && !conv_done) |=> (active_w && !conv_start));

  a_r7_abort_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt_w |=> (!active_w && !conv_start));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> (bus_rdata[3:0] == 4'h0));
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .conv_start(conv_start), .conv_done(conv_done), .conv_chan(conv_chan),
  .active_w(active_w), .trig_hw_w(trig_hw_w), .hw_rise_w(hw_rise_w),
  .chan_wr_w(chan_wr_w), .abort_evt_w(abort_evt_w), .start_evt_w(start_evt_w)
);

// File: tb/adc_trig_ctrl_test.sv
module adc_trig_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       hw_trig = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_start;
  logic [4:0] conv_chan;
  logic       cmp_en;
  logic       cmp_gt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .cmp_en(cmp_en), .cmp_gt(cmp_gt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
  endtask

  function automatic logic [7:0] exp_status(input logic act, input logic [2:0] cfg);
    return {act, cfg, 4'b0000};
  endfunction

  initial begin
    logic [7:0] r;
    logic       on;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(1'b0, r); check("R1 chan reset", r, 8'h1F);
    rd(1'b1, r); check("R1 status reset", r, 8'h00);
    check("R1 start reset", conv_start, 0);

    for (int c = 0; c < 32; c++) begin
      on = (c != 31);
      wr(1'b0, {3'b111, c[4:0]});
      check("R2 start pulse", conv_start, on);
      check("R2 chan out", conv_chan, c);
      rd(1'b1, r); check("R2 active set", r[7], on);
      rd(1'b0, r); check("R8 chan readback", r, c);
      tick();
      check("R2 single cycle", conv_start, 0);
      done_pulse();
      rd(1'b1, r); check("R3 done clears", r[7], 0);
    end

    done_pulse();
    rd(1'b1, r); check("R3 idle done", r[7], 0);

    wr(1'b0, 8'h05);
    tick();
    wr(1'b0, 8'h06);
    check("R2 restart pulse", conv_start, 1);
    check("R2 restart chan", conv_chan, 6);
    rd(1'b1, r); check("R2 restart active", r[7], 1);

    wr(1'b0, 8'h1F);
    check("R7 abort no start", conv_start, 0);
    rd(1'b1, r); check("R7 abort clears", r[7], 0);
    tick();
    check("R7 abort quiet", conv_start, 0);
    wr(1'b0, 8'h1F);
    check("R7 idle off no start", conv_start, 0);

    for (int s = 0; s < 8; s++) begin
      wr(1'b1, {1'b1, s[2:0], 4'hF});
      rd(1'b1, r); check("R8 status rw", r, exp_status(1'b0, s[2:0]));
      check("R9 cmp_en", cmp_en, s[1]);
      check("R9 cmp_gt", cmp_gt, s[0]);
    end

    wr(1'b1, 8'h40);
    wr(1'b0, 8'h03);
    check("R6 hw write no start", conv_start, 0);
    check("R6 hw write chan", conv_chan, 3);
    rd(1'b1, r); check("R6 hw write idle", r, 8'h40);

    for (int k = 0; k < 4; k++) begin
      wr(1'b0, {3'b000, 5'(k * 7 + 1)});
      check("R6 no start on write", conv_start, 0);
      hw_trig = 1'b1;
      tick();
      check("R4 edge start", conv_start, 1);
      check("R4 edge chan", conv_chan, k * 7 + 1);
      tick();
      check("R4 level no repeat", conv_start, 0);
      hw_trig = 1'b0;
      tick();
      hw_trig = 1'b1;
      tick();
      check("R5 busy edge ignored", conv_start, 0);
      rd(1'b1, r); check("R5 still active", r[7], 1);
      done_pulse();
      rd(1'b1, r); check("R3 hw done clears", r[7], 0);
      hw_trig = 1'b0;
      tick();
    end

    wr(1'b0, 8'h1F);
    hw_trig = 1'b1;
    tick();
    check("R4 off chan no start", conv_start, 0);
    hw_trig = 1'b0;
    tick();

    wr(1'b1, 8'h00);
    wr(1'b0, 8'h02);
    tick();
    done_pulse();
    hw_trig = 1'b1;
    tick();
    check("R6 sw mode edge ignored", conv_start, 0);
    rd(1'b1, r); check("R6 sw mode edge idle", r[7], 0);
    hw_trig = 1'b0;
    tick();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule